// File: doc/BRIEF.md
# Eight-bit single-cycle processor core

`tiny_core` is an 8-bit processor that retires one instruction on every rising clock edge. Instruction fetch and data access run on separate ports: the core drives an 8-bit instruction address and receives a 22-bit instruction word in the same cycle. It also drives a data address, write data and a write enable, and it receives read data combinationally. A 16-bit display port carries a value and a write strobe. The strobe is high for exactly those cycles in which a display instruction executes. A halt output shows that the current instruction is halt.

The core holds eight general registers, and register 0 is wired to zero. Each cycle, a combinational decoder turns the opcode into a control word. That word selects the ALU operation, the second ALU operand, the register write-back source, the memory and display strobes, and one of five next-PC selections. The selections are STEP (PC+1), HOLD (halt), JUMP_IMM (target is imm), JUMP_REG (target is REG[rs]) and BRANCH (PC+imm when the condition holds, otherwise PC+1). The PC register is the only sequential state outside the register file. A synchronous active-high reset clears the PC and every register.

Top module: `tiny_core`

## Requirements
- R1: Synchronous reset sets the instruction address to 0. Halt is opcode 0, so an all-zero word is halt. While it executes, `halted` is 1 and the instruction address does not change.
- R2: The instruction word places the opcode in bits 21:17, rd in 16:14, rs in 13:11, rt in 10:8 and imm in 7:0. The display instruction (opcode 1) drives `disp_data` = {REG[rs], REG[rt]} and raises `disp_we`. No other opcode raises `disp_we`.
- R3: Register 0 always reads as zero, and a write that targets it is discarded.
- R4: Opcode 2 sets REG[rd] to imm. Opcode 3 copies REG[rs] into REG[rd].
- R5: Register ALU opcodes 4 to 11 compute REG[rd] = REG[rs] op REG[rt], in the order add, sub, and, or, xor, not (bitwise inverse of REG[rs]), shift-left, shift-right. Shifts are logical, and a shift count of 8 or more gives 0.
- R6: Immediate ALU opcodes 12 to 18 are add, sub, and, or, xor, shift-left and shift-right, in that order, with imm in place of REG[rt].
- R7: Load (opcode 19) and store (opcode 20) use the address REG[rs]+imm, modulo 256. Store drives REG[rt] as write data and raises `dmem_we`. Load writes the read data into REG[rd]. No other opcode raises `dmem_we`.
- R8: Opcode 21 jumps to imm. Opcode 22 jumps to REG[rs].
- R9: Opcode 23 jumps to imm and writes the address of the next instruction (PC+1) into REG[rd].
- R10: Opcodes 24 to 27 branch when REG[rs] < REG[rt], REG[rs] >= REG[rt], REG[rs] == REG[rt] and REG[rs] != REG[rt], in that order, with both operands compared as two's-complement values. A taken branch moves to PC + imm, where imm is a signed 8-bit offset from the branch itself. A branch that is not taken moves to PC+1.
- R11: Opcodes 28 to 31 write no register, no memory and no display, and move to PC+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 8 | Address of the current instruction (the PC) |
| imem_data | input | 22 | Instruction word at `imem_addr` |
| dmem_addr | output | 8 | Data memory address |
| dmem_wdata | output | 8 | Store data |
| dmem_rdata | input | 8 | Load data at `dmem_addr` |
| dmem_we | output | 1 | Data memory write enable |
| disp_data | output | 16 | Display value |
| disp_we | output | 1 | Display write strobe |
| halted | output | 1 | Current instruction is halt |

## Verification
The bench runs one program that fills registers with a negative value and a positive value. A core that compared branch operands without sign would send the less-than branch the wrong way, and the program would reach a halt early. It also branches backwards in a count-down loop and forwards past trap instructions, so an offset applied from PC+1 would land one word too far and show a wrong or missing value. The link jump returns to a display of the saved address, which exposes a link value of PC instead of PC+1. Other parts of the program write to register 0, form a store address that wraps past 255, and execute an undefined opcode between two reads of the same registers.

// File: rtl/tc_pkg.sv
package tc_pkg;

    localparam int OPC_W = 5;

    localparam logic [OPC_W-1:0] OP_HALT  = 5'd0;
    localparam logic [OPC_W-1:0] OP_SHOW  = 5'd1;
    localparam logic [OPC_W-1:0] OP_LDI   = 5'd2;
    localparam logic [OPC_W-1:0] OP_COPY  = 5'd3;
    localparam logic [OPC_W-1:0] OP_ADD   = 5'd4;
    localparam logic [OPC_W-1:0] OP_SUB   = 5'd5;
    localparam logic [OPC_W-1:0] OP_AND   = 5'd6;
    localparam logic [OPC_W-1:0] OP_OR    = 5'd7;
    localparam logic [OPC_W-1:0] OP_XOR   = 5'd8;
    localparam logic [OPC_W-1:0] OP_NOT   = 5'd9;
    localparam logic [OPC_W-1:0] OP_SHL   = 5'd10;
    localparam logic [OPC_W-1:0] OP_SHR   = 5'd11;
    localparam logic [OPC_W-1:0] OP_ADDI  = 5'd12;
    localparam logic [OPC_W-1:0] OP_SUBI  = 5'd13;
    localparam logic [OPC_W-1:0] OP_ANDI  = 5'd14;
    localparam logic [OPC_W-1:0] OP_ORI   = 5'd15;
    localparam logic [OPC_W-1:0] OP_XORI  = 5'd16;
    localparam logic [OPC_W-1:0] OP_SHLI  = 5'd17;
    localparam logic [OPC_W-1:0] OP_SHRI  = 5'd18;
    localparam logic [OPC_W-1:0] OP_LOAD  = 5'd19;
    localparam logic [OPC_W-1:0] OP_STORE = 5'd20;
    localparam logic [OPC_W-1:0] OP_JMP   = 5'd21;
    localparam logic [OPC_W-1:0] OP_JREG  = 5'd22;
    localparam logic [OPC_W-1:0] OP_JLINK = 5'd23;
    localparam logic [OPC_W-1:0] OP_BLT   = 5'd24;
    localparam logic [OPC_W-1:0] OP_BGE   = 5'd25;
    localparam logic [OPC_W-1:0] OP_BEQ   = 5'd26;
    localparam logic [OPC_W-1:0] OP_BNE   = 5'd27;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_XOR = 3'd4,
        ALU_NOT = 3'd5,
        ALU_SHL = 3'd6,
        ALU_SHR = 3'd7
    } alu_op_e;

    typedef enum logic [2:0] {
        WB_ALU  = 3'd0,
        WB_IMM  = 3'd1,
        WB_MEM  = 3'd2,
        WB_LINK = 3'd3,
        WB_MOVE = 3'd4
    } wb_sel_e;

    // next-PC selection, STEP must stay the all-zero value
    typedef enum logic [2:0] {
        FLOW_STEP     = 3'd0,
        FLOW_HOLD     = 3'd1,
        FLOW_JUMP_IMM = 3'd2,
        FLOW_JUMP_REG = 3'd3,
        FLOW_BRANCH   = 3'd4
    } flow_e;

    typedef enum logic [1:0] {
        COND_LT = 2'd0,
        COND_GE = 2'd1,
        COND_EQ = 2'd2,
        COND_NE = 2'd3
    } cond_e;

    typedef struct packed {
        logic    reg_we;
        wb_sel_e wb_sel;
        alu_op_e alu_op;
        logic    b_from_imm;
        logic    mem_we;
        logic    disp_we;
        logic    halt;
        flow_e   flow;
        cond_e   cond;
    } ctrl_t;

endpackage

// File: rtl/tc_decode.sv
module tc_decode
    import tc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 3,
    localparam int INSTR_W = OPC_W + 3 * IDX_W + DATA_W
) (
    input  logic [INSTR_W-1:0] instr,
    output ctrl_t              ctrl,
    output logic [IDX_W-1:0]   rd,
    output logic [IDX_W-1:0]   rs,
    output logic [IDX_W-1:0]   rt,
    output logic [DATA_W-1:0]  imm
);

    localparam int IMM_LO = 0;
    localparam int RT_LO  = DATA_W;
    localparam int RS_LO  = RT_LO + IDX_W;
    localparam int RD_LO  = RS_LO + IDX_W;
    localparam int OPC_LO = RD_LO + IDX_W;

    logic [OPC_W-1:0] opc;

    assign opc = instr[OPC_LO +: OPC_W];
    assign rd  = instr[RD_LO  +: IDX_W];
    assign rs  = instr[RS_LO  +: IDX_W];
    assign rt  = instr[RT_LO  +: IDX_W];
    assign imm = instr[IMM_LO +: DATA_W];

    always_comb begin
        ctrl = '0;
        unique case (opc)
            OP_HALT: begin
                ctrl.halt = 1'b1;
                ctrl.flow = FLOW_HOLD;
            end
            OP_SHOW: ctrl.disp_we = 1'b1;
            OP_LDI: begin
                ctrl.reg_we = 1'b1;
                ctrl.wb_sel = WB_IMM;
            end
            OP_COPY: begin
                ctrl.reg_we = 1'b1;
                ctrl.wb_sel = WB_MOVE;
            end
            OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_NOT, OP_SHL, OP_SHR: begin
                ctrl.reg_we = 1'b1;
                ctrl.alu_op = alu_op_e'(opc - OP_ADD);
            end
            OP_ADDI: begin ctrl.reg_we = 1'b1; ctrl.b_from_imm = 1'b1; ctrl.alu_op = ALU_ADD; end
            OP_SUBI: begin ctrl.reg_we = 1'b1; ctrl.b_from_imm = 1'b1; ctrl.alu_op = ALU_SUB; end
            OP_ANDI: begin ctrl.reg_we = 1'b1; ctrl.b_from_imm = 1'b1; ctrl.alu_op = ALU_AND; end
            OP_ORI:  begin ctrl.reg_we = 1'b1; ctrl.b_from_imm = 1'b1; ctrl.alu_op = ALU_OR;  end
            OP_XORI: begin ctrl.reg_we = 1'b1; ctrl.b_from_imm = 1'b1; ctrl.alu_op = ALU_XOR; end
            OP_SHLI: begin ctrl.reg_we = 1'b1; ctrl.b_from_imm = 1'b1; ctrl.alu_op = ALU_SHL; end
            OP_SHRI: begin ctrl.reg_we = 1'b1; ctrl.b_from_imm = 1'b1; ctrl.alu_op = ALU_SHR; end
            OP_LOAD: begin
                ctrl.reg_we     = 1'b1;
                ctrl.wb_sel     = WB_MEM;
                ctrl.b_from_imm = 1'b1;
            end
            OP_STORE: begin
                ctrl.mem_we     = 1'b1;
                ctrl.b_from_imm = 1'b1;
            end
            OP_JMP:  ctrl.flow = FLOW_JUMP_IMM;
            OP_JREG: ctrl.flow = FLOW_JUMP_REG;
            OP_JLINK: begin
                ctrl.flow   = FLOW_JUMP_IMM;
                ctrl.reg_we = 1'b1;
                ctrl.wb_sel = WB_LINK;
            end
            OP_BLT: begin ctrl.flow = FLOW_BRANCH; ctrl.cond = COND_LT; end
            OP_BGE: begin ctrl.flow = FLOW_BRANCH; ctrl.cond = COND_GE; end
            OP_BEQ: begin ctrl.flow = FLOW_BRANCH; ctrl.cond = COND_EQ; end
            OP_BNE: begin ctrl.flow = FLOW_BRANCH; ctrl.cond = COND_NE; end
            default: ctrl = '0;   // unassigned opcodes retire as no-ops
        endcase
    end

endmodule

// File: rtl/tc_regfile.sv
module tc_regfile #(
    parameter int DATA_W = 8,
    parameter int NREGS  = 8,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr_a,
    input  logic [IDX_W-1:0]  raddr_b,
    output logic [DATA_W-1:0] rdata_a,
    output logic [DATA_W-1:0] rdata_b
);

    logic [DATA_W-1:0] view [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_slot
        if (g == 0) begin : g_zero
            assign view[g] = '0;
        end else begin : g_reg
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else if (we && waddr == IDX_W'(g)) begin
                    q <= wdata;
                end
            end
            assign view[g] = q;
        end
    end

    assign rdata_a = view[raddr_a];
    assign rdata_b = view[raddr_b];

endmodule

// File: rtl/tc_alu.sv
module tc_alu
    import tc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);

    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_XOR: y = a ^ b;
            ALU_NOT: y = ~a;
            ALU_SHL: y = a << b;   // counts >= DATA_W clear the result
            ALU_SHR: y = a >> b;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/tc_pc_unit.sv
module tc_pc_unit
    import tc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  flow_e             flow,
    input  cond_e             cond,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [DATA_W-1:0] imm,
    output logic [DATA_W-1:0] pc,
    output logic [DATA_W-1:0] pc_plus1
);

    logic [DATA_W-1:0] pc_next;
    logic              taken;

    assign pc_plus1 = pc + 1'b1;

    always_comb begin
        unique case (cond)
            COND_LT: taken = $signed(opnd_a) <  $signed(opnd_b);
            COND_GE: taken = $signed(opnd_a) >= $signed(opnd_b);
            COND_EQ: taken = opnd_a == opnd_b;
            COND_NE: taken = opnd_a != opnd_b;
            default: taken = 1'b0;
        endcase
    end

    // address and offset share one width, so modular add equals signed offset
    always_comb begin
        unique case (flow)
            FLOW_STEP:     pc_next = pc_plus1;
            FLOW_HOLD:     pc_next = pc;
            FLOW_JUMP_IMM: pc_next = imm;
            FLOW_JUMP_REG: pc_next = opnd_a;
            FLOW_BRANCH:   pc_next = taken ? pc + imm : pc_plus1;
            default:       pc_next = pc_plus1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else begin
            pc <= pc_next;
        end
    end

endmodule

// File: rtl/tiny_core.sv
module tiny_core
    import tc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NREGS  = 8,
    localparam int IDX_W   = $clog2(NREGS),
    localparam int INSTR_W = OPC_W + 3 * IDX_W + DATA_W
) (
    input  logic                clk,
    input  logic                rst,
    output logic [DATA_W-1:0]   imem_addr,
    input  logic [INSTR_W-1:0]  imem_data,
    output logic [DATA_W-1:0]   dmem_addr,
    output logic [DATA_W-1:0]   dmem_wdata,
    input  logic [DATA_W-1:0]   dmem_rdata,
    output logic                dmem_we,
    output logic [2*DATA_W-1:0] disp_data,
    output logic                disp_we,
    output logic                halted
);

    ctrl_t             ctrl;
    logic [IDX_W-1:0]  rd, rs, rt;
    logic [DATA_W-1:0] imm;
    logic [DATA_W-1:0] rs_val, rt_val;
    logic [DATA_W-1:0] alu_b, alu_y;
    logic [DATA_W-1:0] wb_data;
    logic [DATA_W-1:0] pc, pc_plus1;

    tc_decode #(.DATA_W(DATA_W), .IDX_W(IDX_W)) dec_i (
        .instr (imem_data),
        .ctrl  (ctrl),
        .rd    (rd),
        .rs    (rs),
        .rt    (rt),
        .imm   (imm)
    );

    tc_regfile #(.DATA_W(DATA_W), .NREGS(NREGS)) rf_i (
        .clk     (clk),
        .rst     (rst),
        .we      (ctrl.reg_we),
        .waddr   (rd),
        .wdata   (wb_data),
        .raddr_a (rs),
        .raddr_b (rt),
        .rdata_a (rs_val),
        .rdata_b (rt_val)
    );

    assign alu_b = ctrl.b_from_imm ? imm : rt_val;

    tc_alu #(.DATA_W(DATA_W)) alu_i (
        .op (ctrl.alu_op),
        .a  (rs_val),
        .b  (alu_b),
        .y  (alu_y)
    );

    tc_pc_unit #(.DATA_W(DATA_W)) pcu_i (
        .clk      (clk),
        .rst      (rst),
        .flow     (ctrl.flow),
        .cond     (ctrl.cond),
        .opnd_a   (rs_val),
        .opnd_b   (rt_val),
        .imm      (imm),
        .pc       (pc),
        .pc_plus1 (pc_plus1)
    );

    always_comb begin
        unique case (ctrl.wb_sel)
            WB_ALU:  wb_data = alu_y;
            WB_IMM:  wb_data = imm;
            WB_MEM:  wb_data = dmem_rdata;
            WB_LINK: wb_data = pc_plus1;
            WB_MOVE: wb_data = rs_val;
            default: wb_data = alu_y;
        endcase
    end

    assign imem_addr  = pc;
    assign dmem_addr  = alu_y;
    assign dmem_wdata = rt_val;
    assign dmem_we    = ctrl.mem_we;
    assign disp_data  = {rs_val, rt_val};
    assign disp_we    = ctrl.disp_we;
    assign halted     = ctrl.halt;

endmodule

// File: rtl/tiny_core_chk.sv
module tiny_core_chk #(
    parameter int DATA_W  = 8,
    parameter int INSTR_W = 22
) (
    input logic                clk,
    input logic                rst,
    input logic [DATA_W-1:0]   imem_addr,
    input logic [INSTR_W-1:0]  imem_data,
    input logic                dmem_we,
    input logic [2*DATA_W-1:0] disp_data,
    input logic                disp_we,
    input logic                halted
);

    logic [4:0] opc;
    assign opc = imem_data[INSTR_W-1 -: 5];

    assert_reset_pc_R1: assert property (@(posedge clk)
        rst |=> imem_addr == '0);

    assert_halt_hold_R1: assert property (@(posedge clk) disable iff (rst)
        halted |=> $stable(imem_addr));

    assert_disp_only_R2: assert property (@(posedge clk) disable iff (rst)
        disp_we |-> opc == 5'd1);

    assert_zero_reg_R3: assert property (@(posedge clk) disable iff (rst)
        (disp_we && imem_data[13:11] == 3'd0 && imem_data[10:8] == 3'd0) |-> disp_data == '0);

    assert_alu_step_R5: assert property (@(posedge clk) disable iff (rst)
        (opc >= 5'd4 && opc <= 5'd18) |=> imem_addr == $past(imem_addr) + DATA_W'(1));

    assert_store_only_R7: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> opc == 5'd20);

    assert_jump_imm_R8: assert property (@(posedge clk) disable iff (rst)
        opc == 5'd21 |=> imem_addr == $past(imem_data[DATA_W-1:0]));

    assert_undef_step_R11: assert property (@(posedge clk) disable iff (rst)
        opc >= 5'd28 |=> imem_addr == $past(imem_addr) + DATA_W'(1));

endmodule

bind tiny_core tiny_core_chk #(.DATA_W(DATA_W), .INSTR_W(INSTR_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .imem_addr (imem_addr),
    .imem_data (imem_data),
    .dmem_we   (dmem_we),
    .disp_data (disp_data),
    .disp_we   (disp_we),
    .halted    (halted)
);

// File: tb/tiny_core_tb_top.sv
module tiny_core_tb_top;

    localparam int O_HALT = 0,  O_SHOW = 1,  O_LDI = 2,   O_COPY = 3;
    localparam int O_ADD = 4,   O_SUB = 5,   O_AND = 6,   O_OR = 7;
    localparam int O_XOR = 8,   O_NOT = 9,   O_SHL = 10,  O_SHR = 11;
    localparam int O_ADDI = 12, O_SUBI = 13, O_ANDI = 14, O_ORI = 15;
    localparam int O_XORI = 16, O_SHLI = 17, O_SHRI = 18;
    localparam int O_LOAD = 19, O_STORE = 20;
    localparam int O_JMP = 21,  O_JREG = 22, O_JLINK = 23;
    localparam int O_BLT = 24,  O_BGE = 25,  O_BEQ = 26,  O_BNE = 27;
    localparam int O_UNDEF = 30;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  imem_addr;
    logic [21:0] imem_data;
    logic [7:0]  dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;
    logic [15:0] disp_data;
    logic        disp_we;
    logic        halted;

    logic [21:0] rom [256];
    logic [7:0]  ram [256];

    int checks = 0;
    int errors = 0;

    logic [15:0] exp_disp[$];
    string       exp_disp_tag[$];
    logic [15:0] exp_store[$];

    always #5 clk = ~clk;

    tiny_core dut_i (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_data  (imem_data),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_rdata (dmem_rdata),
        .dmem_we    (dmem_we),
        .disp_data  (disp_data),
        .disp_we    (disp_we),
        .halted     (halted)
    );

    assign imem_data  = rom[imem_addr];
    assign dmem_rdata = ram[dmem_addr];

    always @(posedge clk) begin
        if (dmem_we) ram[dmem_addr] <= dmem_wdata;
    end

    function automatic logic [21:0] ins(input int op, input int rd, input int rs,
                                        input int rt, input int imm);
        logic [4:0] o = op[4:0];
        logic [2:0] d = rd[2:0];
        logic [2:0] s = rs[2:0];
        logic [2:0] t = rt[2:0];
        logic [7:0] i = imm[7:0];
        return {o, d, s, t, i};
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic push_disp(input logic [15:0] v, input string tag);
        exp_disp.push_back(v);
        exp_disp_tag.push_back(tag);
    endtask

    // scoreboard monitor: every strobe pops one expected item
    always @(negedge clk) begin
        if (!rst) begin
            if (disp_we) begin
                if (exp_disp.size() == 0) begin
                    check(1'b0, "R2 unexpected display strobe", disp_data, 0);
                end else begin
                    automatic logic [15:0] e = exp_disp.pop_front();
                    automatic string t = exp_disp_tag.pop_front();
                    check(disp_data == e, t, disp_data, e);
                end
            end
            if (dmem_we) begin
                if (exp_store.size() == 0) begin
                    check(1'b0, "R7 unexpected store", {dmem_addr, dmem_wdata}, 0);
                end else begin
                    automatic logic [15:0] e = exp_store.pop_front();
                    check({dmem_addr, dmem_wdata} == e, "R7 store addr/data",
                          {dmem_addr, dmem_wdata}, e);
                end
            end
        end
    end

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) begin
            rom[i] = '0;
            ram[i] = '0;
        end
    endtask

    initial begin
        clear_mem();

        // R1: all-zero program halts at address 0
        do_reset();
        @(negedge clk);
        check(imem_addr == 8'd0, "R1 reset address", imem_addr, 0);
        check(halted == 1'b1, "R1 halt status", halted, 1);
        repeat (3) @(negedge clk);
        check(imem_addr == 8'd0, "R1 PC frozen on halt", imem_addr, 0);
        check(disp_we == 1'b0 && dmem_we == 1'b0, "R1 no strobes in halt",
              {disp_we, dmem_we}, 0);

        // main program
        rst = 1'b1;
        clear_mem();
        rom[0]  = ins(O_LDI, 1, 0, 0, 8'h57);
        rom[1]  = ins(O_SHOW, 0, 0, 1, 0);          push_disp(16'h0057, "R4 ldi");
        rom[2]  = ins(O_LDI, 2, 0, 0, 8'h3C);
        rom[3]  = ins(O_SHOW, 0, 2, 1, 0);          push_disp(16'h3C57, "R2 concat order");
        rom[4]  = ins(O_LDI, 0, 0, 0, 8'hFF);
        rom[5]  = ins(O_SHOW, 0, 0, 0, 0);          push_disp(16'h0000, "R3 r0 write ignored");
        rom[6]  = ins(O_COPY, 3, 1, 0, 0);
        rom[7]  = ins(O_SHOW, 0, 0, 3, 0);          push_disp(16'h0057, "R4 copy");
        rom[8]  = ins(O_ADD, 4, 1, 2, 0);
        rom[9]  = ins(O_SUB, 5, 1, 2, 0);
        rom[10] = ins(O_SHOW, 0, 4, 5, 0);          push_disp(16'h931B, "R5 add/sub");
        rom[11] = ins(O_AND, 4, 1, 2, 0);
        rom[12] = ins(O_OR, 5, 1, 2, 0);
        rom[13] = ins(O_SHOW, 0, 4, 5, 0);          push_disp(16'h147F, "R5 and/or");
        rom[14] = ins(O_XOR, 4, 1, 2, 0);
        rom[15] = ins(O_NOT, 5, 1, 0, 0);
        rom[16] = ins(O_SHOW, 0, 4, 5, 0);          push_disp(16'h6BA8, "R5 xor/not");
        rom[17] = ins(O_LDI, 6, 0, 0, 3);
        rom[18] = ins(O_SHL, 4, 1, 6, 0);
        rom[19] = ins(O_SHR, 5, 1, 6, 0);
        rom[20] = ins(O_SHOW, 0, 4, 5, 0);          push_disp(16'hB80A, "R5 shifts");
        rom[21] = ins(O_ADDI, 4, 1, 0, 8'h10);
        rom[22] = ins(O_SUBI, 5, 1, 0, 8'h60);
        rom[23] = ins(O_SHOW, 0, 4, 5, 0);          push_disp(16'h67F7, "R6 addi/subi");
        rom[24] = ins(O_ANDI, 4, 1, 0, 8'h0F);
        rom[25] = ins(O_ORI, 5, 1, 0, 8'h80);
        rom[26] = ins(O_SHOW, 0, 4, 5, 0);          push_disp(16'h07D7, "R6 andi/ori");
        rom[27] = ins(O_XORI, 4, 1, 0, 8'hFF);
        rom[28] = ins(O_SHLI, 5, 1, 0, 1);
        rom[29] = ins(O_SHOW, 0, 4, 5, 0);          push_disp(16'hA8AE, "R6 xori/shli");
        rom[30] = ins(O_SHRI, 4, 1, 0, 4);
        rom[31] = ins(O_SHOW, 0, 0, 4, 0);          push_disp(16'h0005, "R6 shri");
        rom[32] = ins(O_LDI, 7, 0, 0, 8'h20);
        rom[33] = ins(O_STORE, 0, 7, 1, 8'h05);     exp_store.push_back(16'h2557);
        rom[34] = ins(O_STORE, 0, 7, 2, 8'hFF);     exp_store.push_back(16'h1F3C);
        rom[35] = ins(O_LOAD, 4, 7, 0, 8'h05);
        rom[36] = ins(O_LOAD, 5, 7, 0, 8'hFF);
        rom[37] = ins(O_SHOW, 0, 4, 5, 0);          push_disp(16'h573C, "R7 load");
        rom[38] = ins(O_JMP, 0, 0, 0, 41);
        rom[39] = ins(O_SHOW, 0, 1, 1, 0);
        rom[40] = ins(O_HALT, 0, 0, 0, 0);
        rom[41] = ins(O_LDI, 3, 0, 0, 45);
        rom[42] = ins(O_JREG, 0, 3, 0, 0);
        rom[43] = ins(O_SHOW, 0, 1, 1, 0);
        rom[44] = ins(O_HALT, 0, 0, 0, 0);
        rom[45] = ins(O_JLINK, 6, 0, 0, 62);
        rom[46] = ins(O_SHOW, 0, 0, 6, 0);          push_disp(16'h002E, "R9 link value");
        rom[47] = ins(O_LDI, 3, 0, 0, 8'hF0);
        rom[48] = ins(O_BLT, 0, 3, 1, 3);
        rom[49] = ins(O_SHOW, 0, 1, 1, 0);
        rom[50] = ins(O_HALT, 0, 0, 0, 0);
        rom[51] = ins(O_BGE, 0, 3, 1, 3);
        rom[52] = ins(O_SHOW, 0, 0, 3, 0);          push_disp(16'h00F0, "R10 signed blt/bge");
        rom[53] = ins(O_BEQ, 0, 1, 3, 3);
        rom[54] = ins(O_BNE, 0, 1, 3, 2);
        rom[55] = ins(O_HALT, 0, 0, 0, 0);
        rom[56] = ins(O_LDI, 5, 0, 0, 3);
        rom[57] = ins(O_SHOW, 0, 0, 5, 0);          push_disp(16'h0003, "R10 loop 3");
                                                    push_disp(16'h0002, "R10 loop 2");
                                                    push_disp(16'h0001, "R10 loop 1");
        rom[58] = ins(O_SUBI, 5, 5, 0, 1);
        rom[59] = ins(O_BNE, 0, 5, 0, 8'hFE);
        rom[60] = ins(O_BGE, 0, 1, 3, 4);
        rom[61] = ins(O_HALT, 0, 0, 0, 0);
        rom[62] = ins(O_JREG, 0, 6, 0, 0);
        rom[63] = ins(O_HALT, 0, 0, 0, 0);
        rom[64] = ins(O_UNDEF, 1, 2, 3, 8'hAA);
        rom[65] = ins(O_SHOW, 0, 1, 2, 0);          push_disp(16'h573C, "R11 undefined no-op");
        rom[66] = ins(O_BEQ, 0, 2, 2, 2);
        rom[67] = ins(O_SHOW, 0, 0, 0, 0);
        rom[68] = ins(O_HALT, 0, 0, 0, 0);

        do_reset();
        begin
            int n;
            for (n = 0; n < 2000 && !halted; n++) @(negedge clk);
            if (n >= 2000) check(1'b0, "R1 watchdog expired before halt", n, 2000);
        end
        check(imem_addr == 8'd68, "R8 R10 final halt address", imem_addr, 68);
        check(exp_disp.size() == 0, "R2 display strobes missing", exp_disp.size(), 0);
        check(exp_store.size() == 0, "R7 store strobes missing", exp_store.size(), 0);
        check(ram[8'h25] == 8'h57, "R7 memory at 0x25", ram[8'h25], 8'h57);
        check(ram[8'h1F] == 8'h3C, "R7 wrapped address 0x1F", ram[8'h1F], 8'h3C);
        repeat (2) @(negedge clk);
        check(imem_addr == 8'd68 && halted, "R1 stays halted", imem_addr, 68);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule